// File: doc/BRIEF.md
# Ternary Associative Processing Array

A word-parallel, bit-serial processing store built from three-state cells: each cell holds 0, 1 or don't-care. A search compares one ternary argument with every stored word at once. The per-word mismatch result is folded into one of two selector vectors, P and S. Reads and writes then work on whichever words a selector marks. A read ORs the marked words column by column onto a bus. A write changes the marked words under a ternary argument, either storing values or erasing cells to don't-care. The selectors can also shift by one word with wrap-around, which is the only way neighbouring words exchange information.

An outside sequencer builds arguments and issues one command per cycle as a single-cycle strobe. All results are registered and can be seen on the cycle after the command. Each selector has a zero flag that the sequencer can use as a branch condition.

Top module: `tern_array`

## Requirements
- R1: After an asynchronous reset (rst_ni low), every cell holds 0, P and S are all zeros, rd_bus_o is 0 and both zero flags are 1.
- R2: Cell and argument codes are 2'b00 = 0, 2'b01 = 1, 2'b10 = don't-care, and 2'b11 is treated as don't-care. A cell mismatches only when the cell is 0 and the argument is 1, or the cell is 1 and the argument is 0. A word mismatches when any of its cells mismatches.
- R3: A search (op 0) forms a word vector from the mismatch, inverted when mis_inv_i=1. It then updates the selector named by dest_i (0 = P, 1 = S) by cmb_i (0 = AND, 1 = OR, 2 or 3 = replace). The other selector is unchanged.
- R4: Read and write act on words chosen by src_i (0 = P, 1 = S, 2 or 3 = none), with the choice inverted when sel_inv_i=1.
- R5: A read (op 1) loads rd_bus_o, on the next cycle, with the column-wise OR of the chosen words, where only cells holding 1 contribute. rd_bus_o holds its value under every other command.
- R6: A normal write (op 2) stores 0 or 1 where the argument is 0 or 1. Argument don't-care cells, and words that are not chosen, keep their contents.
- R7: A special write (op 3) stores don't-care where the argument is 0 or 1. Argument don't-care cells keep their contents.
- R8: A shift (op 4) moves the selector named by dest_i one word with wrap-around. With dir_i=1, word i takes the value of word i-1 and word 0 takes the last word. With dir_i=0, word i takes the value of word i+1 and the last word takes word 0.
- R9: A fill (op 5) sets every bit of the named selector to fill_val_i.
- R10: A mark (op 6) loads the named selector with a single 1 at word idx_i.
- R11: p_zero_o and s_zero_o are 1 exactly when P, respectively S, holds no 1.
- R12: Read, write and no-op (op 7) commands, and cycles with cmd_valid_i=0, leave both selectors unchanged. Without cmd_valid_i, no cell changes either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe, one command per cycle |
| cmd_op_i | input | 3 | Operation code |
| dest_i | input | 1 | Target selector for search, shift, fill, mark (0 P, 1 S) |
| src_i | input | 2 | Word choice for read and write |
| sel_inv_i | input | 1 | Invert the word choice |
| cmb_i | input | 2 | Combine mode for search |
| mis_inv_i | input | 1 | Use the complement of the mismatch vector |
| arg_i | input | 2*CELLS | Ternary argument, two bits per cell |
| dir_i | input | 1 | Shift direction |
| fill_val_i | input | 1 | Fill value |
| idx_i | input | $clog2(WORDS) | Word index for mark |
| rd_bus_o | output | CELLS | Registered read result |
| p_o | output | WORDS | Selector P |
| s_o | output | WORDS | Selector S |
| p_zero_o | output | 1 | P holds no 1 |
| s_zero_o | output | 1 | S holds no 1 |

## Verification
The bench targets the don't-care corners. Argument X against a stored 0 or 1, and a stored X against any argument, must never mismatch; a design that got this wrong would drop matching words from the selector. Words erased by a special write must read back as zero, and a design that leaked the code bit would show stray ones on the bus. The bench also shifts a selector mark across both ends of the word range, where an off-by-one wrap would lose the mark or duplicate it. Finally it issues writes whose argument is all don't-care, or whose word choice is empty. Later reads then expose any cell that such a write disturbed.

// File: rtl/tern_pkg.sv
package tern_pkg;
  typedef enum logic [1:0] {
    TV_ZERO = 2'b00,
    TV_ONE  = 2'b01,
    TV_DC   = 2'b10
  } tval_e;

  typedef enum logic [2:0] {
    OP_SEARCH  = 3'd0,
    OP_READ    = 3'd1,
    OP_WR_NORM = 3'd2,
    OP_WR_SPEC = 3'd3,
    OP_SHIFT   = 3'd4,
    OP_FILL    = 3'd5,
    OP_MARK    = 3'd6,
    OP_NOP     = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    CMB_AND  = 2'd0,
    CMB_OR   = 2'd1,
    CMB_REPL = 2'd2
  } cmb_e;
endpackage

// File: rtl/tern_word.sv
module tern_word #(
  parameter int CELLS = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [2*CELLS-1:0] arg_i,
  input  logic               wr_en_i,
  input  logic               wr_spec_i,
  output logic               mis_o,
  output logic [CELLS-1:0]   ones_o
);
  import tern_pkg::*;

  logic [2*CELLS-1:0] cell_q;
  logic [2*CELLS-1:0] cell_d;
  logic [CELLS-1:0]   bit_mis;

  for (genvar k = 0; k < CELLS; k++) begin : g_cell
    logic [1:0] c;
    logic [1:0] a;
    logic       a_bin;
    assign c          = cell_q[2*k +: 2];
    assign a          = arg_i[2*k +: 2];
    assign a_bin      = (a == TV_ZERO) || (a == TV_ONE);
    assign bit_mis[k] = ((c == TV_ZERO) && (a == TV_ONE)) ||
                        ((c == TV_ONE)  && (a == TV_ZERO));
    assign ones_o[k]  = (c == TV_ONE);
    always_comb begin
      cell_d[2*k +: 2] = c;
      if (wr_en_i && a_bin) cell_d[2*k +: 2] = wr_spec_i ? TV_DC : a;
    end
  end

  assign mis_o = |bit_mis;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cell_q <= '0;
    else         cell_q <= cell_d;
  end
endmodule

// File: rtl/tern_sel.sv
module tern_sel #(
  parameter int WORDS = 32,
  localparam int IW   = $clog2(WORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_i,
  input  tern_pkg::op_e    op_i,
  input  logic [1:0]       cmb_i,
  input  logic [WORDS-1:0] vec_i,
  input  logic             dir_i,
  input  logic             fill_val_i,
  input  logic [IW-1:0]    idx_i,
  output logic [WORDS-1:0] sel_o,
  output logic             zero_o
);
  import tern_pkg::*;

  logic [WORDS-1:0] q;
  logic [WORDS-1:0] nxt;

  always_comb begin
    nxt = q;
    if (upd_i) begin
      unique case (op_i)
        OP_SEARCH: begin
          case (cmb_e'(cmb_i))
            CMB_AND: nxt = q & vec_i;
            CMB_OR:  nxt = q | vec_i;
            default: nxt = vec_i;
          endcase
        end
        OP_SHIFT: nxt = dir_i ? {q[WORDS-2:0], q[WORDS-1]} : {q[0], q[WORDS-1:1]};
        OP_FILL:  nxt = {WORDS{fill_val_i}};
        OP_MARK: begin
          nxt        = '0;
          nxt[idx_i] = 1'b1;
        end
        default: nxt = q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q      <= '0;
      zero_o <= 1'b1;
    end else begin
      q      <= nxt;
      zero_o <= (nxt == '0);
    end
  end

  assign sel_o = q;
endmodule

// File: rtl/tern_rdor.sv
module tern_rdor #(
  parameter int WORDS = 32,
  parameter int CELLS = 16
) (
  input  logic [WORDS-1:0]       sel_i,
  input  logic [WORDS*CELLS-1:0] ones_i,
  output logic [CELLS-1:0]       bus_o
);
  always_comb begin
    bus_o = '0;
    for (int w = 0; w < WORDS; w++)
      if (sel_i[w]) bus_o = bus_o | ones_i[w*CELLS +: CELLS];
  end
endmodule

// File: rtl/tern_array.sv
module tern_array #(
  parameter int WORDS = 32,
  parameter int CELLS = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cmd_valid_i,
  input  logic [2:0]               cmd_op_i,
  input  logic                     dest_i,
  input  logic [1:0]               src_i,
  input  logic                     sel_inv_i,
  input  logic [1:0]               cmb_i,
  input  logic                     mis_inv_i,
  input  logic [2*CELLS-1:0]       arg_i,
  input  logic                     dir_i,
  input  logic                     fill_val_i,
  input  logic [$clog2(WORDS)-1:0] idx_i,
  output logic [CELLS-1:0]         rd_bus_o,
  output logic [WORDS-1:0]         p_o,
  output logic [WORDS-1:0]         s_o,
  output logic                     p_zero_o,
  output logic                     s_zero_o
);
  import tern_pkg::*;

  op_e                    op;
  logic [WORDS-1:0]       mis_vec;
  logic [WORDS-1:0]       hit_vec;
  logic [WORDS-1:0]       word_sel;
  logic [WORDS*CELLS-1:0] ones_flat;
  logic [CELLS-1:0]       bus_d;
  logic                   is_wr;
  logic                   sel_op;
  logic [1:0]             upd;
  logic [WORDS-1:0]       sel_q [2];
  logic [1:0]             zero_q;

  assign op      = op_e'(cmd_op_i);
  assign is_wr   = cmd_valid_i && (op == OP_WR_NORM || op == OP_WR_SPEC);
  assign sel_op  = cmd_valid_i && (op == OP_SEARCH || op == OP_SHIFT ||
                                   op == OP_FILL   || op == OP_MARK);
  assign upd[0]  = sel_op && !dest_i;
  assign upd[1]  = sel_op &&  dest_i;
  assign hit_vec = mis_vec ^ {WORDS{mis_inv_i}};

  always_comb begin
    case (src_i)
      2'd0:    word_sel = sel_q[0];
      2'd1:    word_sel = sel_q[1];
      default: word_sel = '0;
    endcase
    word_sel = word_sel ^ {WORDS{sel_inv_i}};
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    tern_word #(.CELLS(CELLS)) i_word (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .arg_i     (arg_i),
      .wr_en_i   (is_wr && word_sel[w]),
      .wr_spec_i (op == OP_WR_SPEC),
      .mis_o     (mis_vec[w]),
      .ones_o    (ones_flat[w*CELLS +: CELLS])
    );
  end

  for (genvar v = 0; v < 2; v++) begin : g_sel
    tern_sel #(.WORDS(WORDS)) i_sel (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .upd_i      (upd[v]),
      .op_i       (op),
      .cmb_i      (cmb_i),
      .vec_i      (hit_vec),
      .dir_i      (dir_i),
      .fill_val_i (fill_val_i),
      .idx_i      (idx_i),
      .sel_o      (sel_q[v]),
      .zero_o     (zero_q[v])
    );
  end

  tern_rdor #(.WORDS(WORDS), .CELLS(CELLS)) i_rdor (
    .sel_i  (word_sel),
    .ones_i (ones_flat),
    .bus_o  (bus_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            rd_bus_o <= '0;
    else if (cmd_valid_i && op == OP_READ)  rd_bus_o <= bus_d;
  end

  assign p_o      = sel_q[0];
  assign s_o      = sel_q[1];
  assign p_zero_o = zero_q[0];
  assign s_zero_o = zero_q[1];
endmodule

// File: rtl/tern_array_chk.sv
module tern_array_chk #(
  parameter int WORDS = 32,
  parameter int CELLS = 16
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     cmd_valid_i,
  input logic [2:0]               cmd_op_i,
  input logic                     dest_i,
  input logic [1:0]               src_i,
  input logic                     sel_inv_i,
  input logic                     fill_val_i,
  input logic [$clog2(WORDS)-1:0] idx_i,
  input logic [CELLS-1:0]         rd_bus_o,
  input logic [WORDS-1:0]         p_o,
  input logic [WORDS-1:0]         s_o,
  input logic                     p_zero_o,
  input logic                     s_zero_o
);
  logic is_rw;
  assign is_rw = cmd_valid_i && (cmd_op_i inside {3'd1, 3'd2, 3'd3, 3'd7});

  assert_zero_flags_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p_zero_o == (p_o == '0)) && (s_zero_o == (s_o == '0)));

  assert_fill_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == 3'd5 && !dest_i) |=> (p_o == {WORDS{$past(fill_val_i)}}));

  assert_shift_count_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == 3'd4 && !dest_i) |=> ($countones(p_o) == $countones($past(p_o))));

  assert_mark_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == 3'd6 && dest_i) |=> ($countones(s_o) == 1 && s_o[$past(idx_i)]));

  assert_sel_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmd_valid_i || is_rw) |=> ($stable(p_o) && $stable(s_o)));

  assert_other_sel_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == 3'd0 && !dest_i) |=> $stable(s_o));

  assert_rd_none_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == 3'd1 && src_i[1] && !sel_inv_i) |=> (rd_bus_o == '0));

  assert_rd_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_valid_i && cmd_op_i == 3'd1) |=> $stable(rd_bus_o));
endmodule

bind tern_array tern_array_chk #(.WORDS(WORDS), .CELLS(CELLS)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_op_i    (cmd_op_i),
  .dest_i      (dest_i),
  .src_i       (src_i),
  .sel_inv_i   (sel_inv_i),
  .fill_val_i  (fill_val_i),
  .idx_i       (idx_i),
  .rd_bus_o    (rd_bus_o),
  .p_o         (p_o),
  .s_o         (s_o),
  .p_zero_o    (p_zero_o),
  .s_zero_o    (s_zero_o)
);

// File: tb/test_tern_array.sv
`timescale 1ns/1ps
module test_tern_array;
  import tern_pkg::*;

  localparam int WORDS = 32;
  localparam int CELLS = 16;
  localparam int IW    = $clog2(WORDS);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic dest = 1'b0;
  logic [1:0] src = '0;
  logic sel_inv = 1'b0;
  logic [1:0] cmb = '0;
  logic mis_inv = 1'b0;
  logic [2*CELLS-1:0] arg = '0;
  logic dir = 1'b0;
  logic fill_val = 1'b0;
  logic [IW-1:0] idx = '0;
  logic [CELLS-1:0] rd_bus;
  logic [WORDS-1:0] p_v, s_v;
  logic p_zero, s_zero;

  int checks = 0;
  int bad = 0;

  // reference state
  int               m_cell [WORDS][CELLS];
  logic [WORDS-1:0] m_p = '0, m_s = '0;
  logic [CELLS-1:0] m_bus = '0;

  always #2 clk = ~clk;

  tern_array #(.WORDS(WORDS), .CELLS(CELLS)) i_tern_array (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .dest_i(dest), .src_i(src), .sel_inv_i(sel_inv), .cmb_i(cmb),
    .mis_inv_i(mis_inv), .arg_i(arg), .dir_i(dir), .fill_val_i(fill_val),
    .idx_i(idx), .rd_bus_o(rd_bus), .p_o(p_v), .s_o(s_v),
    .p_zero_o(p_zero), .s_zero_o(s_zero)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(rd_bus === m_bus, tag, "rd_bus", 64'(rd_bus), 64'(m_bus));
    chk(p_v === m_p, tag, "P", 64'(p_v), 64'(m_p));
    chk(s_v === m_s, tag, "S", 64'(s_v), 64'(m_s));
    chk(p_zero === (m_p == '0), "R11", "p_zero", 64'(p_zero), 64'(m_p == '0));
    chk(s_zero === (m_s == '0), "R11", "s_zero", 64'(s_zero), 64'(m_s == '0));
  endtask

  // argument builder: care bit 0 -> don't-care, else value bit
  function automatic logic [2*CELLS-1:0] mk(input logic [CELLS-1:0] care,
                                            input logic [CELLS-1:0] val);
    logic [2*CELLS-1:0] r;
    for (int c = 0; c < CELLS; c++) r[2*c +: 2] = care[c] ? {1'b0, val[c]} : 2'b10;
    return r;
  endfunction

  function automatic int argv(input logic [2*CELLS-1:0] a, input int c);
    logic [1:0] x;
    x = a[2*c +: 2];
    if (x == 2'b00) return 0;
    if (x == 2'b01) return 1;
    return 2;
  endfunction

  task automatic model(input logic v, input logic [2:0] op, input logic d,
                       input logic [1:0] sr, input logic si, input logic [1:0] cm,
                       input logic mi, input logic [2*CELLS-1:0] a, input logic dr,
                       input logic fv, input logic [IW-1:0] ix);
    logic [WORDS-1:0] chosen, vec, old, nw;
    if (!v) return;
    chosen = (sr == 2'd0) ? m_p : (sr == 2'd1) ? m_s : '0;
    if (si) chosen = ~chosen;
    old = d ? m_s : m_p;
    nw  = old;
    case (op)
      3'd0: begin
        for (int w = 0; w < WORDS; w++) begin
          bit mm = 0;
          for (int c = 0; c < CELLS; c++) begin
            int cv = m_cell[w][c];
            int av = argv(a, c);
            if ((cv == 0 && av == 1) || (cv == 1 && av == 0)) mm = 1;
          end
          vec[w] = mm ^ mi;
        end
        if (cm == 2'd0) nw = old & vec;
        else if (cm == 2'd1) nw = old | vec;
        else nw = vec;
      end
      3'd1: begin
        m_bus = '0;
        for (int w = 0; w < WORDS; w++)
          if (chosen[w])
            for (int c = 0; c < CELLS; c++) if (m_cell[w][c] == 1) m_bus[c] = 1'b1;
      end
      3'd2, 3'd3: begin
        for (int w = 0; w < WORDS; w++)
          if (chosen[w])
            for (int c = 0; c < CELLS; c++) begin
              int av = argv(a, c);
              if (av != 2) m_cell[w][c] = (op == 3'd3) ? 2 : av;
            end
      end
      3'd4: for (int i = 0; i < WORDS; i++)
              nw[i] = dr ? old[(i + WORDS - 1) % WORDS] : old[(i + 1) % WORDS];
      3'd5: nw = {WORDS{fv}};
      3'd6: begin nw = '0; nw[ix] = 1'b1; end
      default: ;
    endcase
    if (d) m_s = nw; else m_p = nw;
  endtask

  task automatic step(input logic [2:0] op, input logic d, input logic [1:0] sr,
                      input logic si, input logic [1:0] cm, input logic mi,
                      input logic [2*CELLS-1:0] a, input logic dr, input logic fv,
                      input int ix, input string tag);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; dest = d; src = sr; sel_inv = si; cmb = cm;
    mis_inv = mi; arg = a; dir = dr; fill_val = fv; idx = IW'(ix);
    @(posedge clk);
    model(1'b1, op, d, sr, si, cm, mi, a, dr, fv, IW'(ix));
    @(negedge clk);
    cmd_valid = 1'b0;
    compare(tag);
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_op = 3'd2; src = 2'd0; sel_inv = 1'b1; arg = mk('1, '1);
    @(negedge clk);
    compare(tag);
  endtask

  function automatic logic [CELLS-1:0] pat(input int w);
    logic [CELLS-1:0] r;
    for (int c = 0; c < CELLS; c++) r[c] = ((w + c) % 3 == 0) || (c == w % CELLS);
    return r;
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin : stim
    for (int w = 0; w < WORDS; w++)
      for (int c = 0; c < CELLS; c++) m_cell[w][c] = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    compare("R1");
    // all cells read zero after reset
    step(3'd1, 0, 2'd2, 1, 0, 0, '0, 0, 0, 0, "R1");

    // load distinct patterns word by word
    for (int w = 0; w < 8; w++) begin
      step(3'd6, 0, 0, 0, 0, 0, '0, 0, 0, w, "R10");
      step(3'd2, 0, 2'd0, 0, 0, 0, mk('1, pat(w)), 0, 0, 0, "R6");
    end
    for (int w = 0; w < 8; w++) begin
      step(3'd6, 1, 0, 0, 0, 0, '0, 0, 0, w, "R10");
      step(3'd1, 0, 2'd1, 0, 0, 0, '0, 0, 0, 0, "R5");
    end
    // searches: replace with matches, then AND and OR
    step(3'd0, 1, 0, 0, 2'd2, 1, mk(16'h000F, pat(2)), 0, 0, 0, "R2 R3");
    step(3'd0, 1, 0, 0, 2'd0, 1, mk(16'h00F0, pat(2)), 0, 0, 0, "R3");
    step(3'd0, 1, 0, 0, 2'd1, 0, mk(16'h0001, 16'h0001), 0, 0, 0, "R3");
    step(3'd0, 0, 0, 0, 2'd3, 0, mk('0, '0), 0, 0, 0, "R2");
    step(3'd1, 0, 2'd1, 0, 0, 0, '0, 0, 0, 0, "R4 R5");
    step(3'd1, 0, 2'd1, 1, 0, 0, '0, 0, 0, 0, "R4");
    // special write erases cells, X reads as 0 and never mismatches
    step(3'd6, 1, 0, 0, 0, 0, '0, 0, 0, 4, "R10");
    step(3'd3, 0, 2'd1, 0, 0, 0, mk(16'h00FF, 16'h0000), 0, 0, 0, "R7");
    step(3'd1, 0, 2'd1, 0, 0, 0, '0, 0, 0, 0, "R7");
    step(3'd0, 0, 0, 0, 2'd2, 1, mk(16'h00FF, 16'h00FF), 0, 0, 0, "R2 R7");
    step(3'd3, 0, 2'd1, 0, 0, 0, mk(16'h0000, 16'h0000), 0, 0, 0, "R7");
    step(3'd1, 0, 2'd1, 0, 0, 0, '0, 0, 0, 0, "R7");
    // writes that must leave cells alone
    step(3'd2, 0, 2'd3, 0, 0, 0, mk('1, '1), 0, 0, 0, "R6");
    step(3'd2, 0, 2'd2, 1, 0, 0, mk('0, '1), 0, 0, 0, "R6");
    idle("R12");
    step(3'd1, 0, 2'd2, 1, 0, 0, '0, 0, 0, 0, "R6");
    // shift across both ends
    step(3'd6, 0, 0, 0, 0, 0, '0, 0, 0, 0, "R10");
    step(3'd4, 0, 0, 0, 0, 0, '0, 0, 0, 0, "R8");
    step(3'd4, 0, 0, 0, 0, 0, '0, 1, 0, 0, "R8");
    step(3'd4, 0, 0, 0, 0, 0, '0, 1, 0, 0, "R8");
    step(3'd6, 1, 0, 0, 0, 0, '0, 0, 0, WORDS - 1, "R10");
    step(3'd4, 1, 0, 0, 0, 0, '0, 1, 0, 0, "R8");
    // fill and zero flags
    step(3'd5, 1, 0, 0, 0, 0, '0, 0, 1, 0, "R9");
    step(3'd5, 0, 0, 0, 0, 0, '0, 0, 0, 0, "R9 R11");
    step(3'd7, 0, 0, 0, 0, 0, '0, 0, 0, 0, "R12");
    step(3'd1, 0, 2'd1, 0, 0, 0, '0, 0, 0, 0, "R12");

    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [2*CELLS-1:0] ra;
      logic [2:0] rop;
      string tg;
      for (int c = 0; c < CELLS; c++) ra[2*c +: 2] = 2'($urandom_range(0, 3));
      rop = 3'($urandom_range(0, 7));
      case (rop)
        3'd0: tg = "R2 R3";
        3'd1: tg = "R4 R5";
        3'd2: tg = "R6";
        3'd3: tg = "R7";
        3'd4: tg = "R8";
        3'd5: tg = "R9";
        3'd6: tg = "R10";
        default: tg = "R12";
      endcase
      step(rop, 1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
           1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
           1'($urandom_range(0, 1)), ra, 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 1)), $urandom_range(0, WORDS - 1), tg);
      if (n % 7 == 0) step(3'd1, 0, 2'($urandom_range(0, 1)), 0, 0, 0, '0, 0, 0, 0, "R5");
    end

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule